// File: doc/BRIEF.md
# Sequential Bubble Sort Engine

This block puts eight small unsigned values into ascending order. It does not unroll the sort into a wide comparator network. A controller keeps an outer index and an inner index in registers and steps through the bubble-sort schedule. Each clock cycle it performs one compare and one conditional exchange of two adjacent slots. A one-cycle start request loads all eight input lanes at once. The block is busy for a fixed number of cycles, which does not depend on the data. It then signals completion with a single-cycle pulse. The sorted values stay on a packed output bus until the next load.

The inner index moves downward from the top slot toward the current outer index. As a result, the smallest remaining value sinks into the lowest free slot on each pass. An exchange writes each of the two slots from the other slot's old value on the same edge, so no holding register is needed.

Top module: `bsort_engine`

## Requirements
- R1: A synchronous active-high reset, applied at any time, forces `busy` and `done` low and clears every slot, so that `sorted_vec` reads 0.
- R2: A `start` that is high at a rising edge while the engine is idle loads input lane k (bits 4k+3:4k of `in_vec`) into slot k+1. `sorted_vec` uses the same layout: slot 1 is in bits 3:0 and slot 8 is in bits 31:28. The loaded values are visible on `sorted_vec` in the cycle after the start edge.
- R3: After a load, `busy` is high for exactly 28 cycles. `done` is then high for exactly one cycle with `busy` low, and after that the engine is idle.
- R4: Each busy cycle compares exactly one adjacent pair, slots j-1 and j. The pairs follow this order: outer index i runs from 1 to 7, and for each i the inner index j runs from 8 down to i+1. The pair is exchanged only when slot j-1 is strictly greater than slot j, so equal values stay in place.
- R5: When `done` is high, `sorted_vec` holds the loaded values in ascending order, with the smallest value in slot 1.
- R6: A `start` that arrives while `busy` or `done` is high is ignored, and so is any change on `in_vec` after the load edge. Neither alters the compare sequence, the results or the cycle count.
- R7: A start that arrives after the engine has returned to idle begins a new sort of the newly presented values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load-and-sort request, honoured only when idle |
| in_vec | input | 32 | Eight 4-bit input lanes, lane 0 in bits 3:0 |
| sorted_vec | output | 32 | Slot contents, slot 1 in bits 3:0 up to slot 8 in bits 31:28 |
| busy | output | 1 | High while compare cycles are running |
| done | output | 1 | One-cycle pulse when the sort completes |

## Verification
Two situations are hard to reach from the ports. One is a start request, or a change on the input lanes, that lands exactly on a busy cycle or on the done cycle. The other is a reset that arrives partway through a sort. The bench drives random start pulses and random lane values on every cycle of some runs, and it resets one run in the middle. It also tracks every intermediate swap with a cycle-by-cycle model of the index schedule. This exposes a wrong visiting order or a swap on equal values, which a check of the final result alone would miss.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } bsort_state_e;
endpackage

// File: rtl/bsort_cmp.sv
module bsort_cmp #(
   parameter int ELEM_W = 4
) (
   input  logic [ELEM_W-1:0] lo_val,
   input  logic [ELEM_W-1:0] hi_val,
   output logic              out_of_order
);
   // strictly greater only: equal pairs are left untouched
   always_comb out_of_order = (lo_val > hi_val);
endmodule

// File: rtl/bsort_slot.sv
module bsort_slot #(
   parameter int ELEM_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ELEM_W-1:0] load_val,
   input  logic              wr_en,
   input  logic [ELEM_W-1:0] wr_val,
   output logic [ELEM_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (load)  q <= load_val;
      else if (wr_en) q <= wr_val;
   end
endmodule

// File: rtl/bsort_ctrl.sv
module bsort_ctrl
   import bsort_pkg::*;
#(
   parameter int N_ELEM = 8,
   parameter int IDX_W  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic             load,
   output logic             step,
   output logic [IDX_W-1:0] hi_idx
);
   localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(N_ELEM - 1);
   localparam logic [IDX_W-1:0] FIRST_OUT = IDX_W'(1);

   bsort_state_e     state_q;
   logic [IDX_W-1:0] outer_q;
   logic [IDX_W-1:0] inner_q;
   logic             pass_end;
   logic             last_cmp;

   always_comb begin
      load     = (state_q == ST_IDLE) && start;
      step     = (state_q == ST_RUN);
      busy     = step;
      done     = (state_q == ST_DONE);
      hi_idx   = inner_q;
      pass_end = (inner_q == outer_q);
      last_cmp = pass_end && (outer_q == TOP_IDX);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         outer_q <= FIRST_OUT;
         inner_q <= TOP_IDX;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_RUN;
               outer_q <= FIRST_OUT;
               inner_q <= TOP_IDX;
            end
            ST_RUN: begin
               if (last_cmp) begin
                  state_q <= ST_DONE;
               end else if (pass_end) begin
                  outer_q <= outer_q + 1'b1;
                  inner_q <= TOP_IDX;
               end else begin
                  inner_q <= inner_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   a_r4_inner_above_outer: assert property (@(posedge clk) disable iff (rst)
      busy |-> (inner_q >= outer_q) && (outer_q >= FIRST_OUT));
   a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done && !busy);
   a_r3_done_after_run: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> $past(busy));
   a_r6_start_while_busy: assert property (@(posedge clk) disable iff (rst)
      (busy && start && !last_cmp) |=> busy);
endmodule

// File: rtl/bsort_engine.sv
module bsort_engine #(
   parameter int N_ELEM = 8,
   parameter int ELEM_W = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic [N_ELEM*ELEM_W-1:0] in_vec,
   output logic [N_ELEM*ELEM_W-1:0] sorted_vec,
   output logic                     busy,
   output logic                     done
);
   localparam int IDX_W = (N_ELEM > 2) ? $clog2(N_ELEM) : 1;

   if (N_ELEM < 2) begin : g_bad_count
      $error("bsort_engine: N_ELEM must be at least 2");
   end
   if (ELEM_W < 1) begin : g_bad_width
      $error("bsort_engine: ELEM_W must be at least 1");
   end

   logic             load;
   logic             step;
   logic [IDX_W-1:0] hi_idx;
   logic [IDX_W-1:0] lo_idx;
   logic [ELEM_W-1:0] slot_q [N_ELEM];
   logic [ELEM_W-1:0] lo_val;
   logic [ELEM_W-1:0] hi_val;
   logic              swap;

   bsort_ctrl #(.N_ELEM(N_ELEM), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst(rst), .start(start),
      .busy(busy), .done(done), .load(load), .step(step), .hi_idx(hi_idx)
   );

   always_comb begin
      lo_idx = hi_idx - 1'b1;
      lo_val = slot_q[lo_idx];
      hi_val = slot_q[hi_idx];
   end

   logic out_of_order;
   bsort_cmp #(.ELEM_W(ELEM_W)) u_cmp (
      .lo_val(lo_val), .hi_val(hi_val), .out_of_order(out_of_order)
   );
   assign swap = step && out_of_order;

   for (genvar k = 0; k < N_ELEM; k++) begin : g_slot
      logic              wr_en;
      logic [ELEM_W-1:0] wr_val;
      always_comb begin
         wr_en  = swap && ((IDX_W'(k) == hi_idx) || (IDX_W'(k) == lo_idx));
         wr_val = (IDX_W'(k) == hi_idx) ? lo_val : hi_val;
      end
      bsort_slot #(.ELEM_W(ELEM_W)) u_slot (
         .clk(clk), .rst(rst), .load(load),
         .load_val(in_vec[k*ELEM_W +: ELEM_W]),
         .wr_en(wr_en), .wr_val(wr_val), .q(slot_q[k])
      );
      assign sorted_vec[k*ELEM_W +: ELEM_W] = slot_q[k];
   end

   for (genvar k = 0; k < N_ELEM - 1; k++) begin : g_order_chk
      a_r5_ascending: assert property (@(posedge clk) disable iff (rst)
         done |-> (slot_q[k] <= slot_q[k+1]));
   end

   a_r4_swap_changes: assert property (@(posedge clk) disable iff (rst)
      (step && out_of_order) |=> (sorted_vec != $past(sorted_vec)));
   a_r4_ordered_holds: assert property (@(posedge clk) disable iff (rst)
      (step && !out_of_order) |=> $stable(sorted_vec));
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (sorted_vec == '0) && !busy && !done);
endmodule

// File: tb/bsort_engine_bench.sv
module bsort_engine_bench;
   localparam int N = 8;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [31:0]  in_vec = '0;
   logic [31:0]  sorted_vec;
   logic         busy;
   logic         done;

   int n_tests = 0;
   int n_fail  = 0;
   logic [W-1:0] m [N];

   always #10 clk = ~clk;

   bsort_engine #(.N_ELEM(N), .ELEM_W(W)) u_bsort_engine (
      .clk(clk), .rst(rst), .start(start), .in_vec(in_vec),
      .sorted_vec(sorted_vec), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pack_model();
      logic [31:0] v;
      for (int k = 0; k < N; k++) v[k*W +: W] = m[k];
      return v;
   endfunction

   function automatic logic [31:0] ref_sort(input logic [31:0] v);
      logic [W-1:0] a [N];
      logic [W-1:0] t;
      logic [31:0]  r;
      for (int k = 0; k < N; k++) a[k] = v[k*W +: W];
      for (int p = 0; p < N; p++)
         for (int q = 0; q < N - 1 - p; q++)
            if (a[q] > a[q+1]) begin t = a[q]; a[q] = a[q+1]; a[q+1] = t; end
      for (int k = 0; k < N; k++) r[k*W +: W] = a[k];
      return r;
   endfunction

   // one full sort; noisy drives random start/in_vec during the run (R6)
   task automatic run_sort(input logic [31:0] vec, input bit noisy);
      int o, h;
      logic [W-1:0] t;
      @(negedge clk);
      in_vec = vec;
      start  = 1'b1;
      @(negedge clk);
      start = noisy ? 1'($urandom % 2) : 1'b0;
      if (noisy) in_vec = $urandom;
      for (int k = 0; k < N; k++) m[k] = vec[k*W +: W];
      chk(sorted_vec == vec, "R2 load", sorted_vec, vec);
      chk(busy == 1'b1, "R3 busy after load", 32'(busy), 32'd1);
      o = 1; h = N - 1;
      for (int s = 1; s <= 28; s++) begin
         if (m[h-1] > m[h]) begin t = m[h-1]; m[h-1] = m[h]; m[h] = t; end
         if (h == o) begin o++; h = N - 1; end else h--;
         @(negedge clk);
         chk(sorted_vec == pack_model(), noisy ? "R6 step under noise" : "R4 step",
             sorted_vec, pack_model());
         chk(busy == (s < 28), "R3 busy length", 32'(busy), 32'(s < 28));
         chk(done == (s == 28), "R3 done timing", 32'(done), 32'(s == 28));
         if (s < 28) begin
            start = noisy ? 1'($urandom % 2) : 1'b0;
            if (noisy) in_vec = $urandom;
         end else begin
            start = noisy ? 1'($urandom % 2) : 1'b0; // lands on done cycle
         end
      end
      chk(sorted_vec == ref_sort(vec), "R5 final order", sorted_vec, ref_sort(vec));
      @(negedge clk);
      start = 1'b0;
      chk(!busy && !done, "R3 idle after done", {30'd0, busy, done}, 32'd0);
      chk(sorted_vec == ref_sort(vec), "R6 result kept", sorted_vec, ref_sort(vec));
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(sorted_vec == 32'd0 && !busy && !done, "R1 reset state", sorted_vec, 32'd0);

      run_sort(32'h0123_4567, 1'b0);   // descending slots
      run_sort(32'h7654_3210, 1'b0);   // already ascending
      run_sort(32'h5555_5555, 1'b0);   // all equal
      run_sort(32'hF0F0_0F0F, 1'b0);   // extremes with duplicates
      run_sort(32'h0000_0000, 1'b0);
      run_sort(32'h1F2E_3D4C, 1'b1);   // R6 noise
      for (int r = 0; r < 20; r++) run_sort($urandom, r[0]);  // R7 back-to-back new sorts

      // R1: reset in the middle of a sort
      @(negedge clk);
      in_vec = 32'h9ABC_DEF1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(sorted_vec == 32'd0 && !busy && !done, "R1 mid-run reset", sorted_vec, 32'd0);
      rst = 1'b0;
      run_sort(32'h3141_5926, 1'b0);   // R7 fresh sort after reset

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule